// File: doc/BRIEF.md
# Bitmap Pixel Address Generator

This block turns a pixel coordinate into a place in a packed bitmap that lives in a 1 MB byte-addressed memory. For a given X/Y coordinate it returns three things: the byte address, the bit position of the pixel inside that byte, and a mask that covers the pixel's bits. The memory bus and any read-modify-write sequencing are handled outside the block. The block holds two independent image setups, each with its own base address, width in pixels and colour depth. This lets one unit serve both the read side and the write side of a rectangle copy engine: the caller picks a setup for each request.

Setups are loaded through a one-cycle write strobe. The depth is given as a plain bits-per-pixel value. A write that names an unsupported depth is dropped as a whole, and it sets an error flag that stays set until reset. Requests enter with a valid strobe. Each request produces exactly one result, two clock cycles later, and a new request can enter on every cycle.

Top module: `pixAddrGen`

## Requirements
- R1: Two setups exist, selected by a select bit equal to 0 (source) or 1 (destination), both for writes (cfgSel) and for requests (reqSel). A write to one setup leaves the other unchanged.
- R2: After reset, rspValid and cfgErr are 0, and both setups hold base 0, width 0 and 8 bits per pixel.
- R3: With bit index B = (Y*width + X)*bpp, rspAddr equals (base + floor(B/8)) modulo 2^20.
- R4: For 1, 2 or 4 bits per pixel, rspBitOfs equals B mod 8, and rspMask equals (2^bpp - 1) shifted left by rspBitOfs. Pixels are packed from bit 0 upward inside each byte.
- R5: For 8 bits per pixel, rspBitOfs is 0 and rspMask is 0x00FF.
- R6: For 16 bits per pixel, rspAddr has bit 0 cleared (even even when the base is odd), rspBitOfs is 0 and rspMask is 0xFFFF.
- R7: rspValid is high in the cycle exactly two clock edges after each cycle in which reqValid is high, and low otherwise. Back-to-back requests produce back-to-back results in order.
- R8: A request uses the setup held when it is accepted. A setup write in the same cycle as a request affects only later requests.
- R9: cfgDepth values other than 1, 2, 4, 8 and 16 make the whole write ignored (base, width and depth all keep their old values) and set cfgErr. cfgErr stays 1 until reset, including across later valid writes.
- R10: X, Y and width use the full 12-bit range 0..4095 without overflow inside the index computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Setup write strobe |
| cfgSel | input | 1 | Setup being written: 0 source, 1 destination |
| cfgBase | input | 20 | Base byte address to write |
| cfgWidth | input | 12 | Image width in pixels to write |
| cfgDepth | input | 5 | Bits per pixel to write (1, 2, 4, 8 or 16) |
| reqValid | input | 1 | Request strobe |
| reqSel | input | 1 | Setup used by the request |
| reqX | input | 12 | Pixel column |
| reqY | input | 12 | Pixel row |
| rspValid | output | 1 | Result valid, two cycles after the request |
| rspAddr | output | 20 | Byte address of the pixel |
| rspBitOfs | output | 3 | Bit position of the pixel in its byte |
| rspMask | output | 16 | Mask of the pixel's bits |
| cfgErr | output | 1 | Sticky flag for a rejected depth |

## Verification
The main sweep walks a 16 by 4 patch of coordinates for every depth and for widths of 1, 7 and 320. The source and destination setups are given different bases, widths and depths. This separates a swapped select, a wrong row stride and a wrong shift per depth, and it moves sub-byte pixels through every bit offset. An odd base with 16 bits per pixel exposes a missing even-forcing. A base near the top of memory, together with the 4095 corner, exposes truncation in the index and missing wrap. A stream of back-to-back requests with alternating selects, a setup write in the same cycle as a request, and writes with rejected depths separate the latency, the moment the setup is sampled, and the ignore-and-flag behaviour.

// File: rtl/pagPkg.sv
package pagPkg;
  localparam int DEPTH_W = 5;   // bits-per-pixel value field, up to 16
  localparam int L2_W    = 3;   // log2 of bits per pixel
  localparam int MASK_W  = 16;  // widest pixel

  typedef struct packed {
    logic ld1;  // capture request into first stage
    logic ld2;  // capture first stage into result stage
  } pagStrobeT;

  // Returns {ok, log2(bpp)}; ok only for a single set bit.
  function automatic logic [L2_W:0] decodeDepth(input logic [DEPTH_W-1:0] d);
    logic [L2_W:0] r;
    r = '0;
    for (int i = 0; i < DEPTH_W; i++) begin
      if (d == (DEPTH_W'(1) << i)) r = {1'b1, L2_W'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/pagCtrl.sv
module pagCtrl
  import pagPkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int COORD_W = 12,
  parameter int NUM_SET = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgSel,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [COORD_W-1:0] cfgWidth,
  input  logic [DEPTH_W-1:0] cfgDepth,
  input  logic               reqValid,
  input  logic               reqSel,
  output pagStrobeT          strobe,
  output logic [ADDR_W-1:0]  selBase,
  output logic [COORD_W-1:0] selWidth,
  output logic [L2_W-1:0]    selL2,
  output logic               rspValid,
  output logic               cfgErr
);
  localparam logic [L2_W-1:0] RESET_L2 = L2_W'(3);  // 8 bits per pixel

  logic [L2_W:0]      depthDec;
  logic               depthOk;
  logic [ADDR_W-1:0]  setBase  [NUM_SET];
  logic [COORD_W-1:0] setWidth [NUM_SET];
  logic [L2_W-1:0]    setL2    [NUM_SET];
  logic               valid1, valid2;

  assign depthDec = decodeDepth(cfgDepth);
  assign depthOk  = depthDec[L2_W];

  for (genvar g = 0; g < NUM_SET; g++) begin : gSet
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        setBase[g]  <= '0;
        setWidth[g] <= '0;
        setL2[g]    <= RESET_L2;
      end else if (cfgWrEn && depthOk && (cfgSel == 1'(g))) begin
        setBase[g]  <= cfgBase;
        setWidth[g] <= cfgWidth;
        setL2[g]    <= depthDec[L2_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgErr <= 1'b0;
      valid1 <= 1'b0;
      valid2 <= 1'b0;
    end else begin
      if (cfgWrEn && !depthOk) cfgErr <= 1'b1;
      valid1 <= reqValid;
      valid2 <= valid1;
    end
  end

  always_comb begin
    selBase    = setBase[reqSel];
    selWidth   = setWidth[reqSel];
    selL2      = setL2[reqSel];
    strobe.ld1 = reqValid;
    strobe.ld2 = valid1;
  end

  assign rspValid = valid2;
endmodule

// File: rtl/pagDatapath.sv
module pagDatapath
  import pagPkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  pagStrobeT          strobe,
  input  logic [COORD_W-1:0] reqX,
  input  logic [COORD_W-1:0] reqY,
  input  logic [ADDR_W-1:0]  selBase,
  input  logic [COORD_W-1:0] selWidth,
  input  logic [L2_W-1:0]    selL2,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic [2:0]         rspBitOfs,
  output logic [MASK_W-1:0]  rspMask
);
  localparam int IDX_W  = 2 * COORD_W + 1;
  localparam int MAX_L2 = 4;
  localparam int BIT_W  = (IDX_W + MAX_L2 > ADDR_W + 3) ? IDX_W + MAX_L2 : ADDR_W + 3;

  logic [IDX_W-1:0]  pixIdx, pixIdxQ;
  logic [ADDR_W-1:0] baseQ;
  logic [L2_W-1:0]   l2Q;
  logic [BIT_W-1:0]  bitAddr;
  logic [ADDR_W-1:0] byteAddr;
  logic [2:0]        bitOfs;
  logic [MASK_W:0]   pixBits, ones;
  logic [MASK_W-1:0] pixMask;

  assign pixIdx = IDX_W'(reqY) * IDX_W'(selWidth) + IDX_W'(reqX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixIdxQ <= '0;
      baseQ   <= '0;
      l2Q     <= '0;
    end else if (strobe.ld1) begin
      pixIdxQ <= pixIdx;
      baseQ   <= selBase;
      l2Q     <= selL2;
    end
  end

  always_comb begin
    bitAddr  = BIT_W'(pixIdxQ) << l2Q;
    byteAddr = baseQ + bitAddr[ADDR_W+2:3];
    if (l2Q == L2_W'(MAX_L2)) byteAddr[0] = 1'b0;
    bitOfs   = (l2Q < L2_W'(3)) ? bitAddr[2:0] : 3'd0;
    pixBits  = (MASK_W+1)'(1) << l2Q;
    ones     = ((MASK_W+1)'(1) << pixBits) - (MASK_W+1)'(1);
    pixMask  = ones[MASK_W-1:0] << bitOfs;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspAddr   <= '0;
      rspBitOfs <= '0;
      rspMask   <= '0;
    end else if (strobe.ld2) begin
      rspAddr   <= byteAddr;
      rspBitOfs <= bitOfs;
      rspMask   <= pixMask;
    end
  end
endmodule

// File: rtl/pixAddrGen.sv
module pixAddrGen
  import pagPkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgSel,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [COORD_W-1:0] cfgWidth,
  input  logic [4:0]         cfgDepth,
  input  logic               reqValid,
  input  logic               reqSel,
  input  logic [COORD_W-1:0] reqX,
  input  logic [COORD_W-1:0] reqY,
  output logic               rspValid,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic [2:0]         rspBitOfs,
  output logic [15:0]        rspMask,
  output logic               cfgErr
);
  pagStrobeT          strobe;
  logic [ADDR_W-1:0]  selBase;
  logic [COORD_W-1:0] selWidth;
  logic [L2_W-1:0]    selL2;

  pagCtrl #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .NUM_SET(2)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgBase(cfgBase),
    .cfgWidth(cfgWidth), .cfgDepth(cfgDepth),
    .reqValid(reqValid), .reqSel(reqSel),
    .strobe(strobe), .selBase(selBase), .selWidth(selWidth), .selL2(selL2),
    .rspValid(rspValid), .cfgErr(cfgErr)
  );

  pagDatapath #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqX(reqX), .reqY(reqY),
    .selBase(selBase), .selWidth(selWidth), .selL2(selL2),
    .rspAddr(rspAddr), .rspBitOfs(rspBitOfs), .rspMask(rspMask)
  );
endmodule

// File: rtl/pagChecker.sv
module pagChecker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [4:0]        cfgDepth,
  input logic              reqValid,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspAddr,
  input logic [2:0]        rspBitOfs,
  input logic [15:0]       rspMask,
  input logic              cfgErr
);
  AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == $past(reqValid, 2)); // R7

  AST_MASK_AT_OFS: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspMask[rspBitOfs]); // R4

  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMask == 16'hFFFF) |-> (rspAddr[0] == 1'b0 && rspBitOfs == 3'd0)); // R6

  AST_BYTE_WHOLE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMask == 16'h00FF) |-> rspBitOfs == 3'd0); // R5

  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && $countones(cfgDepth) != 1) |=> cfgErr); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgErr) |-> cfgErr); // R9
endmodule

bind pixAddrGen pagChecker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgDepth(cfgDepth),
  .reqValid(reqValid), .rspValid(rspValid), .rspAddr(rspAddr),
  .rspBitOfs(rspBitOfs), .rspMask(rspMask), .cfgErr(cfgErr)
);

// File: tb/sim_pixAddrGen.sv
`timescale 1ns/1ps
module sim_pixAddrGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [19:0] cfgBase = '0;
  logic [11:0] cfgWidth = '0;
  logic [4:0]  cfgDepth = '0;
  logic        reqValid = 1'b0;
  logic        reqSel = 1'b0;
  logic [11:0] reqX = '0;
  logic [11:0] reqY = '0;
  logic        rspValid;
  logic [19:0] rspAddr;
  logic [2:0]  rspBitOfs;
  logic [15:0] rspMask;
  logic        cfgErr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  longint mBase [2];
  longint mWidth[2];
  int     mBpp  [2];

  always #4 clk = ~clk;  // 125 MHz

  pixAddrGen u0 (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [38:0] model(int s, int x, int y);
    longint idx, bits, a;
    int ofs, m;
    idx = longint'(y) * mWidth[s] + longint'(x);
    bits = idx * mBpp[s];
    a = (mBase[s] + (bits >> 3)) & 64'hFFFFF;
    ofs = 0;
    if (mBpp[s] == 16) begin
      a = a & 64'hFFFFE;
      m = 'hFFFF;
    end else if (mBpp[s] == 8) begin
      m = 'hFF;
    end else begin
      ofs = int'(bits & 7);
      m = ((1 << mBpp[s]) - 1) << ofs;
    end
    return {20'(a), 3'(ofs), 16'(m)};
  endfunction

  function automatic string tagFor(int s);
    if (mBpp[s] == 16) return "R6";
    if (mBpp[s] == 8) return "R5";
    return "R4";
  endfunction

  task automatic cfg(int s, longint base, int w, int d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 1'(s); cfgBase = 20'(base);
    cfgWidth = 12'(w); cfgDepth = 5'(d);
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (d == 1 || d == 2 || d == 4 || d == 8 || d == 16) begin
      mBase[s] = base; mWidth[s] = w; mBpp[s] = d;
    end
  endtask

  task automatic oneReq(int s, int x, int y, string tag);
    logic [38:0] exp;
    exp = model(s, x, y);
    @(negedge clk);
    reqValid = 1'b1; reqSel = 1'(s); reqX = 12'(x); reqY = 12'(y);
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    check({tag, " R3 R1 result"}, {rspValid, rspAddr, rspBitOfs, rspMask}, {1'b1, exp});
  endtask

  initial begin
    int depths[5] = '{1, 2, 4, 8, 16};
    int widths[3] = '{1, 7, 320};
    logic [38:0] expQ[40];
    int sQ[40];

    mBase = '{0, 0}; mWidth = '{0, 0}; mBpp = '{8, 8};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2: reset state at the ports
    check("R2 rspValid", 64'(rspValid), 64'd0);
    check("R2 cfgErr", 64'(cfgErr), 64'd0);
    oneReq(0, 5, 9, "R2");
    oneReq(1, 4095, 3, "R2");

    // R7: no result in the intermediate cycle
    @(negedge clk);
    reqValid = 1'b1; reqSel = 1'b0; reqX = 12'd1; reqY = 12'd0;
    @(negedge clk);
    reqValid = 1'b0;
    check("R7 not early", 64'(rspValid), 64'd0);
    @(negedge clk);
    check("R7 on time", 64'(rspValid), 64'd1);
    @(negedge clk);
    check("R7 single pulse", 64'(rspValid), 64'd0);

    // Main sweep: both setups, every depth, several widths
    for (int di = 0; di < 5; di++) begin
      for (int wi = 0; wi < 3; wi++) begin
        cfg(0, 64'h12345, widths[wi], depths[di]);
        cfg(1, 64'hFFFF3, widths[wi] + 3, depths[(di + 2) % 5]);
        for (int y = 0; y < 4; y++)
          for (int x = 0; x < 16; x++)
            for (int s = 0; s < 2; s++)
              oneReq(s, x, y, tagFor(s));
      end
    end

    // R6: odd base, 16 bits per pixel; R10: corner with base wrap
    cfg(0, 64'h00001, 33, 16);
    oneReq(0, 3, 2, "R6");
    cfg(1, 64'hFFFFF, 4095, 16);
    oneReq(1, 4095, 4095, "R10");
    cfg(1, 64'hFFFFF, 4095, 1);
    oneReq(1, 4095, 4095, "R10");
    oneReq(1, 4094, 4095, "R10");

    // R1: writing one setup leaves the other alone
    cfg(0, 64'h00400, 100, 4);
    cfg(1, 64'h08000, 50, 2);
    cfg(0, 64'h00800, 10, 8);
    oneReq(1, 7, 3, "R1");
    oneReq(0, 7, 3, "R1");

    // R8: setup write in the same cycle as a request
    begin
      logic [38:0] oldExp;
      oldExp = model(0, 9, 2);
      @(negedge clk);
      reqValid = 1'b1; reqSel = 1'b0; reqX = 12'd9; reqY = 12'd2;
      cfgWrEn = 1'b1; cfgSel = 1'b0; cfgBase = 20'h30000; cfgWidth = 12'd64; cfgDepth = 5'd16;
      @(negedge clk);
      reqValid = 1'b0; cfgWrEn = 1'b0;
      mBase[0] = 64'h30000; mWidth[0] = 64; mBpp[0] = 16;
      @(negedge clk);
      check("R8 old setup used", {rspValid, rspAddr, rspBitOfs, rspMask}, {1'b1, oldExp});
      oneReq(0, 9, 2, "R8");
    end

    // R9: rejected depths
    check("R9 no error yet", 64'(cfgErr), 64'd0);
    cfg(1, 64'h55555, 999, 3);
    check("R9 flag raised", 64'(cfgErr), 64'd1);
    oneReq(1, 11, 5, "R9");
    cfg(0, 64'h0AAAA, 17, 0);
    oneReq(0, 11, 5, "R9");
    cfg(0, 64'h0AAAA, 17, 24);
    oneReq(0, 2, 1, "R9");
    cfg(0, 64'h01000, 16, 2);
    check("R9 flag sticky", 64'(cfgErr), 64'd1);
    oneReq(0, 6, 1, "R9");

    // R7: back-to-back stream with alternating setups
    for (int i = 0; i < 42; i++) begin
      @(negedge clk);
      if (i >= 2) check("R7 stream", {rspValid, rspAddr, rspBitOfs, rspMask}, {1'b1, expQ[i-2]});
      if (i < 40) begin
        sQ[i] = i % 2;
        expQ[i] = model(sQ[i], (i * 37) % 4096, (i * 11) % 64);
        reqValid = 1'b1; reqSel = 1'(sQ[i]);
        reqX = 12'((i * 37) % 4096); reqY = 12'((i * 11) % 64);
      end else begin
        reqValid = 1'b0;
      end
    end
    @(negedge clk);
    check("R7 stream end", 64'(rspValid), 64'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule